// File: doc/BRIEF.md
# Center/Edge-Aligned PWM Generator

This block is the timebase and compare stage of a six-channel pulse-width modulator. A single 12-bit counter serves every channel. It advances once per prescaled clock tick and can run as a sawtooth (edge-aligned) or as an up/down triangle (center-aligned). Each channel compares the shared count against its own duty value and drives one raw PWM output. Dead-time, polarity and fault handling are done by a separate output stage that follows this block.

Software-side values reach the block through a load strobe. The strobe captures the presented modulus and the six duty values into a holding stage. These captured values become active only at the end of a PWM period, so a period is never cut short or distorted. While the block is disabled, a captured load is applied right away, which lets the first period start with a valid configuration. A single-cycle `reload_o` pulse marks each period end, so a controller can time its next update from it.

Channel k takes its duty value from `duty_i[12*k +: 12]` and drives `pwm_o[k]`.

Top module: `pwm_align_gen`

## Requirements
- R1: After reset, and before any load, `pwm_o` is all zeros and `reload_o` is low.
- R2: While enabled, the counter advances once every 2^`presc_sel_i` clock cycles: select 0 gives 1, select 1 gives 2, select 2 gives 4 and select 3 gives 8. `reload_o` is high for exactly one clock, the last clock of the final tick of a period.
- R3: With `center_i` = 0 (edge-aligned), the count runs 0, 1, …, modulus−1 and then returns to 0. A period is modulus ticks long, and `reload_o` fires in the tick where the count is modulus−1.
- R4: With `center_i` = 1 (center-aligned), the count runs 0 up to the modulus and then down to 1. A period is 2×modulus ticks long, and `reload_o` fires in the tick where the count is 1 on the way down.
- R5: In edge-aligned mode, a channel whose duty d lies between 1 and modulus−1 is high for the first d ticks of each period.
- R6: In center-aligned mode, a channel whose duty d lies between 1 and modulus−1 is high for 2d−1 ticks per period, placed symmetrically around the count-zero point.
- R7: A duty value of 0 holds the channel low for the whole period. A duty value equal to or above the active modulus holds it high for the whole period.
- R8: Changes on `mod_i` and `duty_i` have no effect on the outputs unless `load_i` is pulsed.
- R9: While running, values captured by `load_i` become active at the first period end that follows the capture. A load in the same clock as `reload_o` waits for the next period end, and the period in progress finishes with the old values.
- R10: While `en_i` is low, the count is held at 0, `pwm_o` is all zeros and `reload_o` stays low. A captured load becomes active within two clocks. After `en_i` rises, the count starts at 0 in that same clock.
- R11: The count never exceeds the active modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operating clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for the prescaler and counter |
| presc_sel_i | input | 2 | Prescaler select, divide by 2^value |
| center_i | input | 1 | 1 selects center-aligned, 0 selects edge-aligned |
| mod_i | input | 12 | Modulus value presented for loading |
| duty_i | input | 72 | Six 12-bit duty values, channel k at bits 12k+11..12k |
| load_i | input | 1 | Capture strobe for modulus and duty values |
| pwm_o | output | 6 | Raw PWM outputs, one per channel |
| reload_o | output | 1 | One-clock pulse at each period end |

## Verification
Assertions run on every cycle and check four things: the count stays within the active modulus, the count holds between prescaler ticks, the count is zero right after every period-end pulse, and back-to-back ticks happen only at divide-by-one. They also check that active values change only through a pending load, and that a pending load commits the captured values. The pulse widths per channel, the period lengths in both counting modes, the duty extremes, the deferral of a load that lands on a period end and the first period after enable depend on the whole counting sequence. Only the bench's directed scenarios can show these, by measuring full periods at the outputs.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned NUM_CH = 6;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim_w;

  assign lim_w  = DIV_W'((32'd1 << sel_i) - 32'd1);
  // >= keeps the divider safe when the select shrinks mid-count
  assign tick_o = en_i && (div_q >= lim_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + DIV_W'(1);
  end

  // R2
  back_to_back_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(tick_o)) |-> (sel_i == '0));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_align_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          center_i,
  input  logic [CW-1:0] mod_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q, nxt_cnt;
  dir_e          dir_q, nxt_dir;
  logic [CW:0]   inc_w;
  logic          wrap_c;

  assign inc_w = {1'b0, cnt_q} + (CW+1)'(1);

  always_comb begin
    nxt_cnt = cnt_q;
    nxt_dir = dir_q;
    wrap_c  = 1'b0;
    if (center_i) begin
      if (dir_q == DIR_UP && cnt_q < mod_i) begin
        nxt_cnt = inc_w[CW-1:0];
      end else if (cnt_q <= CW'(1)) begin
        // trough: period end
        nxt_cnt = '0;
        nxt_dir = DIR_UP;
        wrap_c  = 1'b1;
      end else begin
        nxt_cnt = cnt_q - CW'(1);
        nxt_dir = DIR_DOWN;
      end
    end else begin
      nxt_dir = DIR_UP;
      if (inc_w >= {1'b0, mod_i}) begin
        nxt_cnt = '0;
        wrap_c  = 1'b1;
      end else begin
        nxt_cnt = inc_w[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!en_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick_i) begin
      cnt_q <= nxt_cnt;
      dir_q <= nxt_dir;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && wrap_c;

  // R11
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) || (cnt_q <= mod_i));
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
  // R3
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int unsigned CW  = 12,
  parameter int unsigned NCH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              wrap_i,
  input  logic [CW-1:0]     mod_i,
  input  logic [NCH*CW-1:0] duty_i,
  output logic [CW-1:0]     mod_o,
  output logic [NCH*CW-1:0] duty_o
);
  logic [CW-1:0]     mod_hold_q, mod_act_q;
  logic [NCH*CW-1:0] duty_hold_q, duty_act_q;
  logic              pend_q;
  logic              commit_w;

  assign commit_w = pend_q && (wrap_i || !en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_hold_q  <= '0;
      duty_hold_q <= '0;
      mod_act_q   <= '0;
      duty_act_q  <= '0;
      pend_q      <= 1'b0;
    end else begin
      if (commit_w) begin
        mod_act_q  <= mod_hold_q;
        duty_act_q <= duty_hold_q;
      end
      if (load_i) begin
        mod_hold_q  <= mod_i;
        duty_hold_q <= duty_i;
        pend_q      <= 1'b1;
      end else if (commit_w) begin
        pend_q      <= 1'b0;
      end
    end
  end

  assign mod_o  = mod_act_q;
  assign duty_o = duty_act_q;

  // R8
  no_spurious_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_q |=> ($stable(mod_act_q) && $stable(duty_act_q)));
  // R9
  commit_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |=> ((mod_act_q == $past(mod_hold_q)) && (duty_act_q == $past(duty_hold_q))));
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int unsigned CW = 12
) (
  input  logic          en_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] mod_i,
  input  logic [CW-1:0] duty_i,
  output logic          pwm_o
);
  logic full_w;

  assign full_w = (duty_i >= mod_i);
  assign pwm_o  = en_i && (duty_i != '0) && (full_w || (cnt_i < duty_i));
endmodule

// File: rtl/pwm_align_gen.sv
module pwm_align_gen
  import pwm_align_pkg::*;
#(
  parameter int unsigned P_CNT_W  = CNT_W,
  parameter int unsigned P_NUM_CH = NUM_CH,
  parameter int unsigned P_SEL_W  = SEL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [P_SEL_W-1:0]          presc_sel_i,
  input  logic                        center_i,
  input  logic [P_CNT_W-1:0]          mod_i,
  input  logic [P_NUM_CH*P_CNT_W-1:0] duty_i,
  input  logic                        load_i,
  output logic [P_NUM_CH-1:0]         pwm_o,
  output logic                        reload_o
);
  logic                        tick_w;
  logic                        wrap_w;
  logic [P_CNT_W-1:0]          cnt_w;
  logic [P_CNT_W-1:0]          mod_act_w;
  logic [P_NUM_CH*P_CNT_W-1:0] duty_act_w;

  pwm_prescaler #(.SEL_W(P_SEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .sel_i  (presc_sel_i),
    .tick_o (tick_w)
  );

  pwm_counter #(.CW(P_CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_w),
    .center_i (center_i),
    .mod_i    (mod_act_w),
    .cnt_o    (cnt_w),
    .wrap_o   (wrap_w)
  );

  pwm_shadow #(.CW(P_CNT_W), .NCH(P_NUM_CH)) u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .load_i (load_i),
    .wrap_i (wrap_w),
    .mod_i  (mod_i),
    .duty_i (duty_i),
    .mod_o  (mod_act_w),
    .duty_o (duty_act_w)
  );

  for (genvar k = 0; k < P_NUM_CH; k++) begin : g_ch
    pwm_compare #(.CW(P_CNT_W)) u_cmp (
      .en_i   (en_i),
      .cnt_i  (cnt_w),
      .mod_i  (mod_act_w),
      .duty_i (duty_act_w[k*P_CNT_W +: P_CNT_W]),
      .pwm_o  (pwm_o[k])
    );
  end

  assign reload_o = wrap_w;

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!reload_o && (pwm_o == '0)));
endmodule

// File: tb/pwm_align_gen_tb_top.sv
module pwm_align_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 12;
  localparam int NCH = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic [1:0]        presc_sel_i = '0;
  logic              center_i = 1'b0;
  logic [CW-1:0]     mod_i = '0;
  logic [NCH*CW-1:0] duty_i = '0;
  logic              load_i = 1'b0;
  logic [NCH-1:0]    pwm_o;
  logic              reload_o;

  int checks = 0;
  int errors = 0;
  int per_len;
  int hi_cnt [NCH];
  bit done = 0;

  pwm_align_gen dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .presc_sel_i (presc_sel_i),
    .center_i    (center_i),
    .mod_i       (mod_i),
    .duty_i      (duty_i),
    .load_i      (load_i),
    .pwm_o       (pwm_o),
    .reload_o    (reload_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_duties(input int d0, d1, d2, d3, d4, d5);
    duty_i[0*CW +: CW] = CW'(d0);
    duty_i[1*CW +: CW] = CW'(d1);
    duty_i[2*CW +: CW] = CW'(d2);
    duty_i[3*CW +: CW] = CW'(d3);
    duty_i[4*CW +: CW] = CW'(d4);
    duty_i[5*CW +: CW] = CW'(d5);
  endtask

  // load while disabled, then run
  task automatic configure(input bit ctr, input int sel, input int m);
    @(negedge clk_i);
    en_i = 1'b0;
    center_i = ctr;
    presc_sel_i = 2'(sel);
    mod_i = CW'(m);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic sync_reload();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (reload_o) return;
    end
    check(1'b0, "sync timeout", 0, 1);
  endtask

  // called at a reload negedge; counts one full period of clocks
  task automatic measure_period();
    per_len = 0;
    for (int k = 0; k < NCH; k++) hi_cnt[k] = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      load_i = 1'b0;
      per_len++;
      for (int k = 0; k < NCH; k++) if (pwm_o[k]) hi_cnt[k]++;
      if (reload_o) return;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    check(pwm_o == '0, "R1 pwm after reset", int'(pwm_o), 0);
    check(reload_o == 1'b0, "R1 reload after reset", int'(reload_o), 0);
  endtask

  task automatic t_idle_load();
    int n;
    set_duties(3, 0, 10, 15, 1, 9);
    @(negedge clk_i);
    center_i = 1'b0; presc_sel_i = 2'd0; mod_i = CW'(10);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(pwm_o == '0, "R10 pwm while disabled", int'(pwm_o), 0);
    check(reload_o == 1'b0, "R10 reload while disabled", int'(reload_o), 0);
    en_i = 1'b1;
    #1;
    check(reload_o == 1'b0, "R10 modulus committed while idle", int'(reload_o), 0);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!reload_o && n < 100);
    check(n == 9, "R10 first period starts at 0", n, 9);
  endtask

  task automatic t_edge();
    configure(1'b0, 0, 10);
    sync_reload();
    measure_period();
    check(per_len == 10, "R3 edge period", per_len, 10);
    check(hi_cnt[0] == 3, "R5 edge duty 3", hi_cnt[0], 3);
    check(hi_cnt[4] == 1, "R5 edge duty 1", hi_cnt[4], 1);
    check(hi_cnt[5] == 9, "R5 edge duty 9", hi_cnt[5], 9);
    check(hi_cnt[1] == 0, "R7 edge duty 0", hi_cnt[1], 0);
    check(hi_cnt[2] == 10, "R7 edge duty = mod", hi_cnt[2], 10);
    check(hi_cnt[3] == 10, "R7 edge duty > mod", hi_cnt[3], 10);
  endtask

  task automatic t_center();
    configure(1'b1, 0, 10);
    sync_reload();
    measure_period();
    check(per_len == 20, "R4 center period", per_len, 20);
    check(hi_cnt[0] == 5, "R6 center duty 3", hi_cnt[0], 5);
    check(hi_cnt[4] == 1, "R6 center duty 1", hi_cnt[4], 1);
    check(hi_cnt[5] == 17, "R6 center duty 9", hi_cnt[5], 17);
    check(hi_cnt[1] == 0, "R7 center duty 0", hi_cnt[1], 0);
    check(hi_cnt[2] == 20, "R7 center duty = mod", hi_cnt[2], 20);
    check(hi_cnt[3] == 20, "R7 center duty > mod", hi_cnt[3], 20);
  endtask

  task automatic t_presc();
    configure(1'b0, 3, 10);
    sync_reload();
    measure_period();
    check(per_len == 80, "R2 divide by 8 period", per_len, 80);
    check(hi_cnt[0] == 24, "R2 divide by 8 duty 3", hi_cnt[0], 24);
    set_duties(2, 0, 5, 5, 1, 4);
    configure(1'b1, 1, 5);
    sync_reload();
    measure_period();
    check(per_len == 20, "R2 divide by 2 center period", per_len, 20);
    check(hi_cnt[0] == 6, "R2 divide by 2 center duty 2", hi_cnt[0], 6);
  endtask

  task automatic t_buffer();
    set_duties(3, 0, 10, 15, 1, 9);
    configure(1'b0, 0, 10);
    sync_reload();
    mod_i = CW'(6);
    duty_i[0*CW +: CW] = CW'(4);
    measure_period();
    check(per_len == 10, "R8 period without load", per_len, 10);
    check(hi_cnt[0] == 3, "R8 duty without load", hi_cnt[0], 3);
    // load coincides with this period end: deferred one period
    load_i = 1'b1;
    measure_period();
    check(per_len == 10, "R9 old period kept", per_len, 10);
    check(hi_cnt[0] == 3, "R9 old duty kept", hi_cnt[0], 3);
    measure_period();
    check(per_len == 6, "R9 new period", per_len, 6);
    check(hi_cnt[0] == 4, "R9 new duty", hi_cnt[0], 4);
  endtask

  task automatic t_disable();
    int bad;
    @(negedge clk_i);
    en_i = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (pwm_o != '0 || reload_o) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R10 quiet when disabled", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_idle_load();
    t_edge();
    t_center();
    t_presc();
    t_buffer();
    t_disable();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule